// File: doc/BRIEF.md
# Dual-Mode Divider Configuration Loader

This block stores the divider settings of a fractional-N frequency synthesizer: the pre-divider, the feedback divider with its integer and 12-bit fractional parts, two output dividers, two mode bits and two test-select bits. Downstream divider counters read the registered words it presents. The feedback ratio the synthesizer applies is the integer part plus the fraction divided by 4096. A fraction of 2048 is therefore one half.

Settings arrive by one of two paths. While the parallel strobe is low, the integer fields follow dedicated pins, and they freeze when that strobe rises. While the parallel strobe is high, a serial clock shifts a 31-bit frame into a shift register. A transfer strobe then copies the frame into the outputs, and they hold when that strobe falls. Only the serial path can write the fractional part.

All three strobes and the serial data cross into the system clock through two-flop synchronizers. The serial clock is edge-detected there. A TEST output reports a test-select function in serial mode and stays low in parallel mode.

Top module: `divcfg_loader`

## Requirements
- R1: During and right after reset, the fraction, mode bits and test-select bits are zero and TEST is low. The integer fields (pre-divider, feedback integer, both output dividers) equal the parallel pins.
- R2: While `par_load_n` is low, `p_div`, `mint_div`, `na_div` and `nb_div` follow `pin_p`, `pin_mint`, `pin_na` and `pin_nb` within a few system clocks.
- R3: After `par_load_n` rises, the integer outputs keep the pin values from the moment of the rise, and later pin changes have no effect.
- R4: A parallel load never changes `mfrac_div` or `mode_bits`.
- R5: A rising edge of `ser_clk` shifts `ser_data` into the shift register only while `par_load_n` is high and `ser_load` is low. Edges while `ser_load` is high are ignored.
- R6: The frame is shifted first bit first, and after 31 clocks its fields sit in these positions: test-select [30:29], NB [28:26], NA [25:23], P [22:20], mode [19:18], fraction [17:6], feedback integer [5:0].
- R7: When more than 31 bits are clocked in, the oldest bits leave the top, and only the last 31 bits form the frame.
- R8: While `ser_load` is high (with `par_load_n` high), every output follows the shift register fields. When `ser_load` falls, the outputs hold.
- R9: TEST is low whenever the block is in parallel mode (`par_load_n` low).
- R10: After a serial transfer, TEST is 0 when the test-select bits are 00. For any other code, TEST is 1 exactly when the fraction is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| par_load_n | input | 1 | Parallel strobe: low = transparent, rise = latch |
| ser_load | input | 1 | Serial transfer strobe |
| ser_clk | input | 1 | Serial shift clock (asynchronous, slow) |
| ser_data | input | 1 | Serial data, sampled on `ser_clk` rise |
| pin_mint | input | 6 | Parallel feedback integer |
| pin_na | input | 3 | Parallel output divider A |
| pin_nb | input | 3 | Parallel output divider B |
| pin_p | input | 3 | Parallel pre-divider |
| p_div | output | 3 | Pre-divider setting |
| mint_div | output | 6 | Feedback integer setting |
| mfrac_div | output | 12 | Feedback fraction setting (value/4096) |
| na_div | output | 3 | Output divider A setting |
| nb_div | output | 3 | Output divider B setting |
| mode_bits | output | 2 | Mode bits from the serial frame |
| test_out | output | 1 | Test indicator |

## Verification
The assertions check the following on every cycle:
- The integer outputs track the pins and the fraction stays still in parallel mode.
- The settings hold when no strobe is active.
- A transfer copies the frame fields.
- The shift register moves only on an enabled serial clock edge.
- TEST is low after any parallel-mode cycle.

Only the bench scenarios can show the rest: the field order of a full frame, the discarding of excess leading bits, the ignoring of shift edges during a transfer, and the TEST value for each test-select code and fraction.

// File: rtl/divcfg_pkg.sv
// Package: shared constants for the divider configuration loader.
// Assumes: the field widths below match the parameters used at the top.
package divcfg_pkg;

    // Code on the test-select bits that forces TEST low in serial mode
    localparam logic [1:0] TSEL_OFF = 2'b00;

    // Operating mode held by the register bank
    typedef enum logic {
        MODE_PAR = 1'b0,
        MODE_SER = 1'b1
    } cfg_mode_e;

endpackage

// File: rtl/divcfg_sync.sv
// Module: multi-bit two-flop (or deeper) synchronizer.
// What it does: carries each asynchronous input bit into the clk domain.
// Assumes: each bit is an independent slow level; reset clears the chain.
module divcfg_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            logic [STAGES-1:0] chain;

            // Shift the raw bit through the flop chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], async_in[b]};
            end

            assign sync_out[b] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/divcfg_edge.sv
// Module: rising-edge detector on synchronized levels.
// What it does: pulses for one clk cycle when a level goes 0 -> 1.
// Assumes: inputs are already in the clk domain.
module divcfg_edge #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);

    logic [WIDTH-1:0] level_q;

    // Remember the previous level
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;

endmodule

// File: rtl/divcfg_shifter.sv
// Module: serial frame shift register.
// What it does: shifts one bit in at the LSB per enabled strobe; oldest bits leave the MSB.
// Assumes: shift_en is a single-cycle pulse per serial clock edge.
module divcfg_shifter #(
    parameter int FRAME_W = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shift_en,
    input  logic               bit_in,
    output logic [FRAME_W-1:0] frame
);

    // Shift the frame on each enabled serial edge
    always_ff @(posedge clk) begin
        if (!rst_n)        frame <= '0;
        else if (shift_en) frame <= {frame[FRAME_W-2:0], bit_in};
    end

    // R5
    // shift_hold_chk
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(frame));

    // R6
    // shift_entry_chk
    shift_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> frame[0] == $past(bit_in));

endmodule

// File: rtl/divcfg_regs.sv
// Module: divider setting register bank.
// What it does: emulates the transparent parallel latch and the serial
//   transfer latch with clocked registers, and derives TEST.
// Assumes: par_level and xfer_level are synchronized levels; parallel mode wins.
module divcfg_regs
    import divcfg_pkg::*;
#(
    parameter int P_W     = 3,
    parameter int N_W     = 3,
    parameter int MINT_W  = 6,
    parameter int FRAC_W  = 12,
    parameter int DS_W    = 2,
    parameter int TSEL_W  = 2,
    parameter int FRAME_W = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               par_level,
    input  logic               xfer_level,
    input  logic [FRAME_W-1:0] frame,
    input  logic [MINT_W-1:0]  pin_mint,
    input  logic [N_W-1:0]     pin_na,
    input  logic [N_W-1:0]     pin_nb,
    input  logic [P_W-1:0]     pin_p,
    output logic [P_W-1:0]     p_div,
    output logic [MINT_W-1:0]  mint_div,
    output logic [FRAC_W-1:0]  mfrac_div,
    output logic [N_W-1:0]     na_div,
    output logic [N_W-1:0]     nb_div,
    output logic [DS_W-1:0]    mode_bits,
    output logic               test_out
);

    // Field offsets inside the frame (LSB end holds the last bits shifted)
    localparam int MINT_LO = 0;
    localparam int FRAC_LO = MINT_LO + MINT_W;
    localparam int DS_LO   = FRAC_LO + FRAC_W;
    localparam int P_LO    = DS_LO + DS_W;
    localparam int NA_LO   = P_LO + P_W;
    localparam int NB_LO   = NA_LO + N_W;
    localparam int TSEL_LO = NB_LO + N_W;

    logic [TSEL_W-1:0] tsel_q;
    cfg_mode_e         mode_q;
    logic              xfer_en;

    assign xfer_en = par_level && xfer_level;

    // Integer fields: follow pins in parallel mode, frame during transfer
    always_ff @(posedge clk) begin
        if (!rst_n || !par_level) begin
            p_div    <= pin_p;
            mint_div <= pin_mint;
            na_div   <= pin_na;
            nb_div   <= pin_nb;
        end else if (xfer_en) begin
            p_div    <= frame[P_LO    +: P_W];
            mint_div <= frame[MINT_LO +: MINT_W];
            na_div   <= frame[NA_LO   +: N_W];
            nb_div   <= frame[NB_LO   +: N_W];
        end
    end

    // Serial-only fields: written by a transfer, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mfrac_div <= '0;
            mode_bits <= '0;
            tsel_q    <= '0;
        end else if (xfer_en) begin
            mfrac_div <= frame[FRAC_LO +: FRAC_W];
            mode_bits <= frame[DS_LO   +: DS_W];
            tsel_q    <= frame[TSEL_LO +: TSEL_W];
        end
    end

    // Track which path last owned the settings
    always_ff @(posedge clk) begin
        if (!rst_n || !par_level) mode_q <= MODE_PAR;
        else if (xfer_en)         mode_q <= MODE_SER;
    end

    // TEST: low in parallel mode or when test-select is off, else fraction-active
    assign test_out = (mode_q == MODE_SER) && (tsel_q != TSEL_OFF) && (mfrac_div != '0);

    // R2
    // par_follow_chk
    par_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !par_level |=> (mint_div == $past(pin_mint)) && (p_div == $past(pin_p)));

    // R4
    // par_frac_keep_chk
    par_frac_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !par_level |=> $stable(mfrac_div) && $stable(mode_bits));

    // R3
    // idle_hold_chk
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (par_level && !xfer_level) |=> $stable(mint_div) && $stable(na_div) && $stable(nb_div));

    // R8
    // xfer_copy_chk
    xfer_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_en |=> mfrac_div == $past(frame[FRAC_LO +: FRAC_W]));

    // R9
    // par_test_low_chk
    par_test_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !par_level |=> !test_out);

endmodule

// File: rtl/divcfg_loader.sv
// Module: top of the dual-mode divider configuration loader.
// What it does: synchronizes strobes and serial data, detects serial clock
//   edges, gates the shifter, and feeds the register bank.
// Assumes: ser_clk phases last well over STAGES+1 system clocks.
module divcfg_loader #(
    parameter int P_W    = 3,
    parameter int N_W    = 3,
    parameter int MINT_W = 6,
    parameter int FRAC_W = 12,
    parameter int DS_W   = 2,
    parameter int TSEL_W = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              par_load_n,
    input  logic              ser_load,
    input  logic              ser_clk,
    input  logic              ser_data,
    input  logic [MINT_W-1:0] pin_mint,
    input  logic [N_W-1:0]    pin_na,
    input  logic [N_W-1:0]    pin_nb,
    input  logic [P_W-1:0]    pin_p,
    output logic [P_W-1:0]    p_div,
    output logic [MINT_W-1:0] mint_div,
    output logic [FRAC_W-1:0] mfrac_div,
    output logic [N_W-1:0]    na_div,
    output logic [N_W-1:0]    nb_div,
    output logic [DS_W-1:0]   mode_bits,
    output logic              test_out
);

    localparam int FRAME_W = TSEL_W + 2 * N_W + P_W + DS_W + FRAC_W + MINT_W;
    localparam int NSYNC   = 4;

    logic [NSYNC-1:0]   raw_in;
    logic [NSYNC-1:0]   synced;
    logic               par_level;
    logic               xfer_level;
    logic               sclk_level;
    logic               sdata_level;
    logic [0:0]         sclk_rise;
    logic               shift_en;
    logic [FRAME_W-1:0] frame;

    assign raw_in = {ser_data, ser_clk, ser_load, par_load_n};
    assign {sdata_level, sclk_level, xfer_level, par_level} = synced;

    divcfg_sync #(.WIDTH(NSYNC), .STAGES(STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (synced)
    );

    divcfg_edge #(.WIDTH(1)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sclk_level),
        .rise  (sclk_rise)
    );

    // Shifting allowed only outside parallel mode and outside a transfer
    assign shift_en = sclk_rise[0] && par_level && !xfer_level;

    divcfg_shifter #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (sdata_level),
        .frame    (frame)
    );

    divcfg_regs #(
        .P_W(P_W), .N_W(N_W), .MINT_W(MINT_W), .FRAC_W(FRAC_W),
        .DS_W(DS_W), .TSEL_W(TSEL_W), .FRAME_W(FRAME_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .par_level  (par_level),
        .xfer_level (xfer_level),
        .frame      (frame),
        .pin_mint   (pin_mint),
        .pin_na     (pin_na),
        .pin_nb     (pin_nb),
        .pin_p      (pin_p),
        .p_div      (p_div),
        .mint_div   (mint_div),
        .mfrac_div  (mfrac_div),
        .na_div     (na_div),
        .nb_div     (nb_div),
        .mode_bits  (mode_bits),
        .test_out   (test_out)
    );

endmodule

// File: tb/tb_divcfg_loader.sv
module tb_divcfg_loader;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        par_load_n = 1'b0;
    logic        ser_load = 1'b0;
    logic        ser_clk = 1'b0;
    logic        ser_data = 1'b0;
    logic [5:0]  pin_mint = '0;
    logic [2:0]  pin_na = '0;
    logic [2:0]  pin_nb = '0;
    logic [2:0]  pin_p = '0;
    logic [2:0]  p_div;
    logic [5:0]  mint_div;
    logic [11:0] mfrac_div;
    logic [2:0]  na_div;
    logic [2:0]  nb_div;
    logic [1:0]  mode_bits;
    logic        test_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    divcfg_loader dut (
        .clk(clk), .rst_n(rst_n), .par_load_n(par_load_n), .ser_load(ser_load),
        .ser_clk(ser_clk), .ser_data(ser_data), .pin_mint(pin_mint), .pin_na(pin_na),
        .pin_nb(pin_nb), .pin_p(pin_p), .p_div(p_div), .mint_div(mint_div),
        .mfrac_div(mfrac_div), .na_div(na_div), .nb_div(nb_div),
        .mode_bits(mode_bits), .test_out(test_out)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [30:0] mk_frame(input logic [1:0] t, input logic [2:0] nb,
        input logic [2:0] na, input logic [2:0] p, input logic [1:0] ds,
        input logic [11:0] fr, input logic [5:0] mi);
        return {t, nb, na, p, ds, fr, mi};
    endfunction

    task automatic set_pins(input logic [5:0] m, input logic [2:0] a,
                            input logic [2:0] b, input logic [2:0] p);
        pin_mint = m; pin_na = a; pin_nb = b; pin_p = p;
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        wait_cyc(4);
        ser_clk = 1'b1;
        wait_cyc(4);
        ser_clk = 1'b0;
        wait_cyc(4);
    endtask

    task automatic send_frame(input logic [30:0] f);
        for (int i = 30; i >= 0; i--) send_bit(f[i]);
    endtask

    task automatic check_all(input string req, input logic [30:0] f);
        chk(req, {29'd0, p_div},   {29'd0, f[22:20]});
        chk(req, {26'd0, mint_div}, {26'd0, f[5:0]});
        chk(req, {20'd0, mfrac_div}, {20'd0, f[17:6]});
        chk(req, {29'd0, na_div},  {29'd0, f[25:23]});
        chk(req, {29'd0, nb_div},  {29'd0, f[28:26]});
        chk(req, {30'd0, mode_bits}, {30'd0, f[19:18]});
    endtask

    function automatic logic exp_test(input logic [30:0] f);
        return (f[30:29] != 2'b00) && (f[17:6] != 12'd0);
    endfunction

    // R1: reset state
    task automatic t_reset();
        set_pins(6'd25, 3'd3, 3'd5, 3'd1);
        rst_n = 1'b0;
        wait_cyc(4);
        chk("R1 mint under reset", {26'd0, mint_div}, 32'd25);
        rst_n = 1'b1;
        wait_cyc(2);
        chk("R1 mfrac", {20'd0, mfrac_div}, 32'd0);
        chk("R1 mode_bits", {30'd0, mode_bits}, 32'd0);
        chk("R1 test", {31'd0, test_out}, 32'd0);
        chk("R1 na", {29'd0, na_div}, 32'd3);
        chk("R1 nb", {29'd0, nb_div}, 32'd5);
        chk("R1 p", {29'd0, p_div}, 32'd1);
    endtask

    // R2: transparent parallel path
    task automatic t_par_follow();
        par_load_n = 1'b0;
        set_pins(6'd63, 3'd7, 3'd0, 3'd6);
        wait_cyc(5);
        chk("R2 mint a", {26'd0, mint_div}, 32'd63);
        chk("R2 na a", {29'd0, na_div}, 32'd7);
        chk("R2 p a", {29'd0, p_div}, 32'd6);
        set_pins(6'd10, 3'd2, 3'd4, 3'd3);
        wait_cyc(5);
        chk("R2 mint b", {26'd0, mint_div}, 32'd10);
        chk("R2 nb b", {29'd0, nb_div}, 32'd4);
        chk("R9 test in parallel", {31'd0, test_out}, 32'd0);
    endtask

    // R3: latch on parallel strobe rise
    task automatic t_par_latch();
        set_pins(6'd33, 3'd1, 3'd2, 3'd5);
        wait_cyc(5);
        par_load_n = 1'b1;
        wait_cyc(6);
        set_pins(6'd7, 3'd6, 3'd6, 3'd0);
        wait_cyc(8);
        chk("R3 mint held", {26'd0, mint_div}, 32'd33);
        chk("R3 na held", {29'd0, na_div}, 32'd1);
        chk("R3 nb held", {29'd0, nb_div}, 32'd2);
        chk("R3 p held", {29'd0, p_div}, 32'd5);
    endtask

    // R5, R6, R8, R10: full frame, ignored edges during transfer
    task automatic t_serial_frame();
        logic [30:0] f;
        f = mk_frame(2'b01, 3'd5, 3'd3, 3'd6, 2'b10, 12'd2048, 6'd25);
        send_frame(f);
        chk("R5 no effect before transfer", {26'd0, mint_div}, 32'd33);
        ser_load = 1'b1;
        wait_cyc(6);
        check_all("R6 field order", f);
        send_bit(1'b1);
        send_bit(1'b0);
        check_all("R5 edges ignored during transfer", f);
        ser_load = 1'b0;
        wait_cyc(6);
        check_all("R8 hold after fall", f);
        chk("R10 test sel 01 frac nonzero", {31'd0, test_out}, {31'd0, exp_test(f)});
    endtask

    // R7: extra leading bits are pushed out
    task automatic t_overlong();
        logic [30:0] f;
        f = mk_frame(2'b00, 3'd2, 3'd4, 3'd1, 2'b01, 12'hABC, 6'd40);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        send_frame(f);
        ser_load = 1'b1;
        wait_cyc(6);
        ser_load = 1'b0;
        wait_cyc(6);
        check_all("R7 last 31 bits", f);
        chk("R10 test sel 00", {31'd0, test_out}, 32'd0);
    endtask

    // R10: remaining test-select codes
    task automatic t_test_codes();
        logic [30:0] f;
        f = mk_frame(2'b10, 3'd1, 3'd1, 3'd1, 2'b00, 12'd0, 6'd20);
        send_frame(f);
        ser_load = 1'b1; wait_cyc(6); ser_load = 1'b0; wait_cyc(6);
        chk("R10 sel 10 frac zero", {31'd0, test_out}, 32'd0);
        f = mk_frame(2'b11, 3'd1, 3'd1, 3'd1, 2'b00, 12'd1, 6'd20);
        send_frame(f);
        ser_load = 1'b1; wait_cyc(6); ser_load = 1'b0; wait_cyc(6);
        chk("R10 sel 11 frac one", {31'd0, test_out}, 32'd1);
    endtask

    // R4, R9: parallel after serial keeps fraction
    task automatic t_par_after_serial();
        set_pins(6'd12, 3'd5, 3'd6, 3'd7);
        par_load_n = 1'b0;
        wait_cyc(6);
        chk("R4 mfrac kept", {20'd0, mfrac_div}, 32'd1);
        chk("R4 mode bits kept", {30'd0, mode_bits}, 32'd0);
        chk("R2 mint after serial", {26'd0, mint_div}, 32'd12);
        chk("R9 test low", {31'd0, test_out}, 32'd0);
        par_load_n = 1'b1;
        wait_cyc(6);
        chk("R9 test low after latch", {31'd0, test_out}, 32'd0);
    endtask

    initial begin
        t_reset();
        t_par_follow();
        t_par_latch();
        t_serial_frame();
        t_overlong();
        t_test_codes();
        t_par_after_serial();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule